// File: doc/BRIEF.md
# Power-Paced Scan Clock Generator

This block paces the test clock of a scan test so that each clock cycle is only as long as its own energy needs. A precomputed energy figure for every test clock cycle arrives in cycle order on a valid/ready stream. The block divides each figure by the power budget, rounds up to whole ticks of the fast base clock, and never lets the result fall below a critical-path floor. There is one floor for shift cycles and another for capture cycles. The result is the length of that test clock period. A conventional scan clock uses the single worst-case period for every cycle. Here low-energy cycles finish early, so the whole test takes close to total energy divided by peak power.

The block also sequences the test itself. For every vector it gives a run of shift cycles with scan-enable high, then one capture cycle with scan-enable low. After the last vector it gives a final unload run of shift cycles. For every period it gives a one-tick clock-enable pulse at the start of the period. It keeps a 32-bit count of the base ticks spent inside test clock periods. When the final unload ends it raises a done flag. A fixed-period reference mode replaces every energy figure with a configured worst-case energy. The divider works sequentially while the current period runs. When the next period is not known in time, the generator holds the test clock low instead of cutting a period short.

Top module: `vp_scan_clkgen`

## Requirements
- R1: After a synchronous active-high reset, and again after a reset in the middle of a run, tck_en, scan_en, done and e_ready are 0 and elapsed is 0.
- R2: A start pulse while idle latches every cfg_* input and clears elapsed and done. A start pulse or any cfg_* change during a run has no effect on that run.
- R3: With V = cfg_vectors and L = cfg_chain (L at least 1), a run has exactly (V+1)·L + V test clock periods. Each vector gives L periods with scan_en = 1 and then one period with scan_en = 0. The run ends with L periods with scan_en = 1. scan_en changes only together with a tck_en pulse, apart from dropping to 0 at the end of the run.
- R4: A period begins with a one-tick tck_en pulse. It lasts max(ceil(E/cfg_pmax), floor, 1) base ticks, where E is that cycle's energy word and cfg_pmax is at least 1.
- R5: The floor is cfg_floor_shift for periods with scan_en = 1 and cfg_floor_capt for periods with scan_en = 0.
- R6: With cfg_fixed = 1, cfg_emax takes the place of E for every period. One energy word per period is still consumed.
- R7: Exactly one energy word is consumed per period, in period order, on cycles where e_valid and e_ready are both 1. e_ready is 1 only while words of the current run remain to be taken.
- R8: When the next period's length is not ready as a period ends, tck_en stays 0 and elapsed does not advance until it is ready. No period is shortened by such a stall.
- R9: elapsed counts the base ticks spent inside periods. At the end of a run it equals the sum of all period lengths. With no floor active and exact division, that sum is the total energy divided by cfg_pmax.
- R10: done rises when the final period ends and stays high until the next start. While done is high, tck_en and e_ready stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only while idle) |
| cfg_vectors | input | 16 | Number of scan vectors |
| cfg_chain | input | 16 | Shift cycles per load or unload (at least 1) |
| cfg_pmax | input | 16 | Power budget divisor (at least 1) |
| cfg_floor_shift | input | 16 | Minimum ticks of a shift period |
| cfg_floor_capt | input | 16 | Minimum ticks of a capture period |
| cfg_fixed | input | 1 | Use cfg_emax for every period |
| cfg_emax | input | 24 | Worst-case energy for the fixed mode |
| e_valid | input | 1 | Energy word available |
| e_data | input | 24 | Energy of the next test clock cycle |
| e_ready | output | 1 | Energy word taken when high with e_valid |
| tck_en | output | 1 | One-tick pulse at the start of each period |
| scan_en | output | 1 | High for shift periods, low for capture |
| elapsed | output | 32 | Base ticks spent inside periods this run |
| done | output | 1 | Final period finished |

## Verification
The hardest situation to reach is a stall that falls exactly on a period boundary. To get there, the energy stream must run dry just as a period ends, and the divider must still be busy when short periods follow one another. The stimulus holds e_valid low for the first ticks of every run and withholds it on a periodic pattern in several table rows. It also mixes zero-energy words with floors of zero, which gives one-tick periods that outrun the divider. The bench then measures each period as the change in elapsed between successive pulses. A stall that shortened or stretched a period would show up there and in the final total.

// File: rtl/vp_scan_pkg.sv
package vp_scan_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

  typedef struct packed {
    logic se;
    logic last;
  } cyc_tag_t;
endpackage

// File: rtl/vp_ceil_div.sv
module vp_ceil_div #(
  parameter int NW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo
);
  localparam int CNTW = $clog2(NW + 1);

  logic [NW-1:0]   q_r;
  logic [DW-1:0]   rem_r;
  logic [DW-1:0]   den_r;
  logic [CNTW-1:0] cnt_r;
  logic            busy_r;
  logic [DW:0]     trial;
  logic            fits;

  // one restoring step per tick
  always_comb begin
    trial = {rem_r, q_r[NW-1]};
    fits  = (trial >= {1'b0, den_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r <= 1'b0;
      fin    <= 1'b0;
      q_r    <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !busy_r) begin
        busy_r <= 1'b1;
        q_r    <= num;
        rem_r  <= '0;
        den_r  <= den;
        cnt_r  <= CNTW'(NW);
      end else if (busy_r) begin
        rem_r <= fits ? DW'(trial - {1'b0, den_r}) : trial[DW-1:0];
        q_r   <= {q_r[NW-2:0], fits};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNTW'(1)) begin
          busy_r <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  // round up: any remainder adds one tick
  assign quo = q_r + {{(NW-1){1'b0}}, |rem_r};
endmodule

// File: rtl/vp_seq.sv
module vp_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  input  logic [CW-1:0] n_vec,
  input  logic [CW-1:0] n_len,
  output logic          cur_se,
  output logic          cur_last
);
  logic [CW-1:0] vec_done;
  logic [CW-1:0] pos;

  // pos == n_len marks the capture slot of a vector
  assign cur_se   = (pos != n_len);
  assign cur_last = cur_se && (vec_done == n_vec) && (pos == n_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      vec_done <= '0;
      pos      <= '0;
    end else if (adv) begin
      if (!cur_se) begin
        pos      <= '0;
        vec_done <= vec_done + 1'b1;
      end else if (pos == n_len - 1'b1 && vec_done != n_vec) begin
        pos <= n_len;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vp_pacer.sv
module vp_pacer #(
  parameter int TW = 24,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          nxt_valid,
  input  logic [TW-1:0] nxt_period,
  input  logic          nxt_se,
  input  logic          nxt_last,
  output logic          take,
  output logic          active,
  output logic          tck_en,
  output logic          scan_en,
  output logic [AW-1:0] elapsed,
  output logic          done
);
  logic [TW-1:0] rem;
  logic          last_r;

  assign take = nxt_valid && (!active || rem == TW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rem     <= '0;
      last_r  <= 1'b0;
      active  <= 1'b0;
      tck_en  <= 1'b0;
      scan_en <= 1'b0;
      elapsed <= '0;
      done    <= 1'b0;
    end else begin
      if (active) elapsed <= elapsed + 1'b1;
      tck_en <= take;
      if (take) begin
        active  <= 1'b1;
        rem     <= nxt_period;
        scan_en <= nxt_se;
        last_r  <= nxt_last;
      end else if (active) begin
        if (rem == TW'(1)) begin
          active <= 1'b0;
          if (last_r) begin
            done    <= 1'b1;
            scan_en <= 1'b0;
          end
        end else begin
          rem <= rem - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vp_scan_clkgen.sv
module vp_scan_clkgen
  import vp_scan_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int FW = 16,
  parameter int EW = 24,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_vectors,
  input  logic [CW-1:0] cfg_chain,
  input  logic [PW-1:0] cfg_pmax,
  input  logic [FW-1:0] cfg_floor_shift,
  input  logic [FW-1:0] cfg_floor_capt,
  input  logic          cfg_fixed,
  input  logic [EW-1:0] cfg_emax,
  input  logic          e_valid,
  input  logic [EW-1:0] e_data,
  output logic          e_ready,
  output logic          tck_en,
  output logic          scan_en,
  output logic [AW-1:0] elapsed,
  output logic          done
);
  localparam int TW = EW;

  run_state_t    st;
  logic [CW-1:0] vec_r, len_r;
  logic [PW-1:0] pmax_r;
  logic [FW-1:0] fs_r, fc_r;
  logic          fixed_r;
  logic [EW-1:0] emax_r;

  logic          more, pend, nxt_valid;
  cyc_tag_t      pend_tag, nxt_tag;
  logic [TW-1:0] nxt_period;

  logic          go_idle;
  logic          acc;
  logic          seq_se, seq_last;
  logic          div_fin;
  logic [TW-1:0] div_quo;
  logic [TW-1:0] floor_w, per_w;
  logic          take;
  logic          pace_active;

  assign go_idle = start && (st == ST_IDLE);
  assign e_ready = (st == ST_RUN) && more && !pend && !nxt_valid;
  assign acc     = e_ready && e_valid;

  vp_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .init(go_idle), .adv(acc),
    .n_vec(vec_r), .n_len(len_r),
    .cur_se(seq_se), .cur_last(seq_last)
  );

  vp_ceil_div #(.NW(EW), .DW(PW)) u_div (
    .clk(clk), .rst(rst), .go(acc),
    .num(fixed_r ? emax_r : e_data), .den(pmax_r),
    .fin(div_fin), .quo(div_quo)
  );

  // period = max(quotient, mode floor, 1)
  always_comb begin
    floor_w = pend_tag.se ? TW'(fs_r) : TW'(fc_r);
    per_w   = (div_quo > floor_w) ? div_quo : floor_w;
    if (per_w == '0) per_w = TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      vec_r      <= '0;
      len_r      <= '0;
      pmax_r     <= '0;
      fs_r       <= '0;
      fc_r       <= '0;
      fixed_r    <= 1'b0;
      emax_r     <= '0;
      more       <= 1'b0;
      pend       <= 1'b0;
      nxt_valid  <= 1'b0;
      pend_tag   <= '0;
      nxt_tag    <= '0;
      nxt_period <= '0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st        <= ST_RUN;
        vec_r     <= cfg_vectors;
        len_r     <= cfg_chain;
        pmax_r    <= cfg_pmax;
        fs_r      <= cfg_floor_shift;
        fc_r      <= cfg_floor_capt;
        fixed_r   <= cfg_fixed;
        emax_r    <= cfg_emax;
        more      <= 1'b1;
        pend      <= 1'b0;
        nxt_valid <= 1'b0;
      end
    end else begin
      if (acc) begin
        pend          <= 1'b1;
        pend_tag.se   <= seq_se;
        pend_tag.last <= seq_last;
        if (seq_last) more <= 1'b0;
      end
      if (div_fin) begin
        pend       <= 1'b0;
        nxt_valid  <= 1'b1;
        nxt_period <= per_w;
        nxt_tag    <= pend_tag;
      end
      if (take) nxt_valid <= 1'b0;
      if (done) st <= ST_IDLE;
    end
  end

  vp_pacer #(.TW(TW), .AW(AW)) u_pace (
    .clk(clk), .rst(rst), .clear(go_idle),
    .nxt_valid(nxt_valid), .nxt_period(nxt_period),
    .nxt_se(nxt_tag.se), .nxt_last(nxt_tag.last),
    .take(take), .active(pace_active),
    .tck_en(tck_en), .scan_en(scan_en), .elapsed(elapsed), .done(done)
  );
endmodule

// File: rtl/vp_scan_clkgen_chk.sv
module vp_scan_clkgen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          tck_en,
  input logic          scan_en,
  input logic          e_ready,
  input logic [AW-1:0] elapsed,
  input logic          done,
  input logic          run_active
);
  AST_ELAPSED_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |->
      (elapsed == $past(elapsed) || elapsed == $past(elapsed) + AW'(1))); // R9

  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start) && !$past(run_active)) |-> $stable(elapsed)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tck_en && !e_ready)); // R10

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R10

  AST_SE_AT_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !done && !tck_en) |-> $stable(scan_en)); // R3
endmodule

bind vp_scan_clkgen vp_scan_clkgen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .tck_en(tck_en), .scan_en(scan_en),
  .e_ready(e_ready), .elapsed(elapsed), .done(done), .run_active(pace_active)
);

// File: tb/vp_scan_clkgen_bench.sv
module vp_scan_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] cfg_vectors, cfg_chain, cfg_pmax, cfg_floor_shift, cfg_floor_capt;
  logic        cfg_fixed;
  logic [23:0] cfg_emax;
  logic        e_valid;
  logic [23:0] e_data;
  logic        e_ready, tck_en, scan_en, done;
  logic [31:0] elapsed;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vp_scan_clkgen u_vp_scan_clkgen (
    .clk(clk), .rst(rst), .start(start),
    .cfg_vectors(cfg_vectors), .cfg_chain(cfg_chain), .cfg_pmax(cfg_pmax),
    .cfg_floor_shift(cfg_floor_shift), .cfg_floor_capt(cfg_floor_capt),
    .cfg_fixed(cfg_fixed), .cfg_emax(cfg_emax),
    .e_valid(e_valid), .e_data(e_data), .e_ready(e_ready),
    .tck_en(tck_en), .scan_en(scan_en), .elapsed(elapsed), .done(done)
  );

  typedef struct packed {
    int v; int l; int p; int fs; int fc; int fx; int emax;
    int seed; int scale; int gap; int ncyc;
  } row_t;

  localparam int NROW = 5;
  localparam row_t ROWS [NROW] = '{
    '{3, 4, 5, 2, 6, 0, 0, 3, 2, 0, 19},
    '{2, 3, 1, 0, 0, 0, 0, 5, 4, 3, 11},
    '{1, 5, 7, 10, 3, 1, 60, 1, 3, 2, 11},
    '{0, 3, 4, 0, 0, 0, 0, 9, 5, 0, 3},
    '{4, 1, 3, 0, 0, 0, 0, 0, 1, 4, 9}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int energy(input row_t r, input int i);
    return ((i * 13 + r.seed) % 23) * r.scale;
  endfunction

  function automatic bit model_se(input row_t r, input int k);
    if (k < r.v * (r.l + 1)) return (k % (r.l + 1)) < r.l;
    return 1'b1;
  endfunction

  function automatic int model_period(input row_t r, input int k);
    int e, q, fl;
    e  = r.fx != 0 ? r.emax : energy(r, k);
    q  = (e + r.p - 1) / r.p;
    fl = model_se(r, k) ? r.fs : r.fc;
    if (fl > q) q = fl;
    if (q < 1) q = 1;
    return q;
  endfunction

  task automatic apply_cfg(input row_t r);
    cfg_vectors = 16'(r.v); cfg_chain = 16'(r.l); cfg_pmax = 16'(r.p);
    cfg_floor_shift = 16'(r.fs); cfg_floor_capt = 16'(r.fc);
    cfg_fixed = r.fx != 0; cfg_emax = 24'(r.emax);
  endtask

  // glitch_t >= 0 pulses start with altered config mid-run (R2)
  task automatic run_case(input int ri, input int glitch_t);
    row_t r;
    int idx, pulses, bad_per, bad_se, sum_exp, sum_e;
    longint prev_el;
    bit hs, fin, v;
    r = ROWS[ri];
    idx = 0; pulses = 0; bad_per = 0; bad_se = 0; sum_exp = 0; sum_e = 0;
    prev_el = 0; hs = 0; fin = 0;
    for (int k = 0; k < r.ncyc; k++) begin
      sum_exp += model_period(r, k);
      sum_e   += energy(r, k);
    end
    @(negedge clk);
    apply_cfg(r);
    start = 1'b1; e_valid = 1'b0;
    for (int t = 0; t < 20000 && !fin; t++) begin
      @(negedge clk);
      start = 1'b0;
      apply_cfg(r);
      if (hs) idx++;
      if (tck_en) begin
        if (pulses > 0 && longint'(elapsed) - prev_el != model_period(r, pulses - 1)) bad_per++;
        if (scan_en != model_se(r, pulses)) bad_se++;
        prev_el = elapsed;
        pulses++;
      end
      if (done) begin
        if (longint'(elapsed) - prev_el != model_period(r, pulses - 1)) bad_per++;
        fin = 1;
      end
      if (t == 14) begin
        check(elapsed == 0 && pulses == 0, $sformatf("R8 row%0d no ticks while stream empty", ri), elapsed, 0);
        check(e_ready == 1'b1, $sformatf("R7 row%0d ready while words needed", ri), e_ready, 1);
      end
      if (t == glitch_t) begin
        start = 1'b1; cfg_vectors = 16'd9; cfg_pmax = 16'd2;
      end
      v = (t >= 15) && (r.gap == 0 || (t % r.gap) != 0);
      e_valid = v;
      e_data  = 24'(energy(r, idx));
      hs = v && e_ready;
    end
    e_valid = 1'b0;
    check(fin, $sformatf("R10 row%0d done reached", ri), fin, 1);
    check(pulses == r.ncyc, $sformatf("R3 row%0d period count", ri), pulses, r.ncyc);
    check(bad_se == 0, $sformatf("R3 R5 row%0d scan_en per period", ri), bad_se, 0);
    check(bad_per == 0, $sformatf("R4 R5 R6 row%0d period lengths", ri), bad_per, 0);
    check(elapsed == 32'(sum_exp), $sformatf("R9 row%0d elapsed total", ri), elapsed, sum_exp);
    check(idx == r.ncyc, $sformatf("R7 row%0d words consumed", ri), idx, r.ncyc);
    if (r.fs == 0 && r.fc == 0 && r.p == 1)
      check(elapsed == 32'(sum_e), $sformatf("R9 row%0d equals energy over budget", ri), elapsed, sum_e);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      e_valid = 1'b1;
      if (!done || tck_en || e_ready) begin
        check(0, $sformatf("R10 row%0d quiet after done", ri), {done, tck_en, e_ready}, 3'b100);
        break;
      end
    end
    check(done && elapsed == 32'(sum_exp), $sformatf("R10 row%0d done held", ri), done, 1);
    e_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; e_valid = 1'b0; e_data = '0;
    apply_cfg(ROWS[0]);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tck_en && !scan_en && !done && !e_ready && elapsed == 0,
          "R1 reset state", {tck_en, scan_en, done, e_ready}, 0);

    for (int ri = 0; ri < NROW; ri++) run_case(ri, -1);

    // R2: start and config change mid-run are ignored
    run_case(0, 60);

    // R1: reset in the middle of a run
    @(negedge clk);
    apply_cfg(ROWS[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; e_valid = 1'b1; e_data = 24'd50;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; e_valid = 1'b0;
    @(negedge clk);
    check(!tck_en && !scan_en && !done && !e_ready && elapsed == 0,
          "R1 mid-run reset", {tck_en, scan_en, done, e_ready}, 0);

    // R2: clean restart after the reset
    run_case(3, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule